// File: doc/BRIEF.md
# Ethernet pause frame generator

This block produces one complete full-duplex flow-control pause frame on a byte-wide transmit stream each time it is asked. A single-cycle request starts a frame. The block then emits the preamble and start delimiter, the reserved multicast destination, the station's own address, the MAC-control type, the pause opcode, the requested pause time, zero padding, and a CRC-32 frame check sequence that it computes as the bytes go out. Every byte of the frame comes from hardware. Nothing is read from a buffer.

The downstream transmit path takes bytes with a valid/ready handshake. A start marker flags the first byte of a frame and an end marker flags the last. A busy flag stays high from the first byte until the last byte has been accepted. The station address and the pause time are captured when a frame starts, so changes to these inputs during a frame do not alter that frame. If a request arrives while a frame is being sent, the block remembers it and starts another frame straight after the current one.

Top module: `pause_frame_gen`

## Requirements
- R1: After reset, tx_valid_o, tx_sop_o, tx_eop_o and busy_o are all low.
- R2: In the cycle after an idle-state request, busy_o and tx_valid_o go high and the first byte is shown with tx_sop_o high. tx_valid_o always equals busy_o.
- R3: A frame has 72 bytes in total. Bytes 0 to 6 are 0x55 and byte 7 is 0xD5.
- R4: Bytes 8 to 13 are 0x01, 0x80, 0xC2, 0x00, 0x00, 0x01.
- R5: Bytes 14 to 19 are station_addr_i, bits [47:40] first and bits [7:0] last. The value used is the one present in the cycle the frame starts.
- R6: Bytes 20 to 23 are 0x88, 0x08, 0x00, 0x01.
- R7: Bytes 24 and 25 are pause_time_i[15:8] then pause_time_i[7:0], captured when the frame starts. Bytes 26 to 67 are 0x00.
- R8: Bytes 68 to 71 are the FCS, sent least significant byte first. The FCS is the complement of a reflected CRC-32 (polynomial 0xEDB88320, initial value 0xFFFFFFFF) over bytes 8 to 67. tx_eop_o is high only on byte 71.
- R9: A byte advances only when tx_valid_o and tx_ready_i are both high. While tx_ready_i is low, tx_data_o and the markers hold.
- R10: A request made while a frame is in progress, including in the cycle its last byte is accepted, is not lost. The next frame starts the cycle after that last byte. Any number of requests during one frame produce exactly one further frame.
- R11: With no request pending, busy_o is low in the cycle after the last byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle request for a pause frame |
| station_addr_i | input | 48 | Source address, first transmitted byte in [47:40] |
| pause_time_i | input | 16 | Pause time in pause quanta |
| tx_ready_i | input | 1 | Downstream accepts the current byte |
| tx_data_o | output | 8 | Current frame byte |
| tx_valid_o | output | 1 | tx_data_o holds a frame byte |
| tx_sop_o | output | 1 | First byte of frame |
| tx_eop_o | output | 1 | Last byte of frame |
| busy_o | output | 1 | Frame in progress |

## Verification
A wrong byte index shows up as a misplaced field within one accepted byte, because every byte is compared with a model built from the requirements. A corrupted CRC register, however, appears only in the four FCS bytes at the end of the frame, up to 60 bytes after the fault. If the pending-request flag is lost or duplicated, the effect appears at the end of the frame as a missing or extra frame, so the bench compares frame counts as well as every cycle's outputs.

// File: rtl/pause_frame_gen.sv
module pause_frame_gen #(
  parameter logic [31:0] CRC_POLY = 32'hEDB88320,
  parameter int PAD_BYTES = 42
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic [47:0] station_addr_i,
  input  logic [15:0] pause_time_i,
  input  logic        tx_ready_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  output logic        tx_sop_o,
  output logic        tx_eop_o,
  output logic        busy_o
);
  localparam int PRE_END  = 8;
  localparam int BODY_END = PRE_END + 18 + PAD_BYTES;
  localparam int LAST     = BODY_END + 3;
  localparam int IW       = $clog2(LAST + 1);

  logic [IW-1:0] idx;
  logic          busy, pend;
  logic [47:0]   sa_q;
  logic [15:0]   pt_q;
  logic [31:0]   crc;
  logic [7:0]    byte_c;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  wire acc   = busy & tx_ready_i;
  wire done  = acc && (idx == IW'(LAST));
  wire rq    = req_i | pend;
  wire start = rq & (~busy | done);
  wire in_crc = (idx >= IW'(PRE_END)) && (idx < IW'(BODY_END));
  wire [31:0] fcs = ~crc;

  always_comb begin
    byte_c = 8'h00;
    if (idx < IW'(PRE_END - 1))        byte_c = 8'h55;
    else if (idx == IW'(PRE_END - 1))  byte_c = 8'hD5;
    else if (idx >= IW'(BODY_END)) begin
      case (idx - IW'(BODY_END))
        IW'(0):  byte_c = fcs[7:0];
        IW'(1):  byte_c = fcs[15:8];
        IW'(2):  byte_c = fcs[23:16];
        default: byte_c = fcs[31:24];
      endcase
    end else begin
      case (idx - IW'(PRE_END))
        IW'(0):  byte_c = 8'h01;
        IW'(1):  byte_c = 8'h80;
        IW'(2):  byte_c = 8'hC2;
        IW'(3):  byte_c = 8'h00;
        IW'(4):  byte_c = 8'h00;
        IW'(5):  byte_c = 8'h01;
        IW'(6):  byte_c = sa_q[47:40];
        IW'(7):  byte_c = sa_q[39:32];
        IW'(8):  byte_c = sa_q[31:24];
        IW'(9):  byte_c = sa_q[23:16];
        IW'(10): byte_c = sa_q[15:8];
        IW'(11): byte_c = sa_q[7:0];
        IW'(12): byte_c = 8'h88;
        IW'(13): byte_c = 8'h08;
        IW'(14): byte_c = 8'h00;
        IW'(15): byte_c = 8'h01;
        IW'(16): byte_c = pt_q[15:8];
        IW'(17): byte_c = pt_q[7:0];
        default: byte_c = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= 1'b0;
      idx  <= '0;
      sa_q <= '0;
      pt_q <= '0;
      crc  <= 32'hFFFFFFFF;
    end else begin
      pend <= busy & ~done & rq;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        sa_q <= station_addr_i;
        pt_q <= pause_time_i;
        crc  <= 32'hFFFFFFFF;
      end else if (done) begin
        busy <= 1'b0;
      end else if (acc) begin
        idx <= idx + 1'b1;
        if (in_crc) crc <= crc_step(crc, byte_c);
      end
    end
  end

  assign tx_data_o  = byte_c;
  assign tx_valid_o = busy;
  assign busy_o     = busy;
  assign tx_sop_o   = busy && (idx == '0);
  assign tx_eop_o   = busy && (idx == IW'(LAST));

  p_busy_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> busy_o);
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_sop_o) && $stable(tx_eop_o));
  p_start_sop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> tx_sop_o && tx_data_o == 8'h55);
  p_idle_after_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eop_o && tx_ready_i && !req_i && !pend |=> !busy_o);
  p_sop_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sop_o && tx_ready_i |=> tx_valid_o && !tx_sop_o && tx_data_o == 8'h55);
endmodule

// File: tb/test_pause_frame_gen.sv
module test_pause_frame_gen;
  logic clk = 0, rst_n = 0, req = 0, rdy = 1;
  logic [47:0] sa = 48'h02AB_CD12_3456;
  logic [15:0] pt = 16'h1234;
  logic [7:0] d;
  logic v, sop, eop, bsy;

  always #4 clk = ~clk;

  pause_frame_gen i_pause_frame_gen (
    .clk(clk), .rst_n(rst_n), .req_i(req), .station_addr_i(sa),
    .pause_time_i(pt), .tx_ready_i(rdy), .tx_data_o(d),
    .tx_valid_o(v), .tx_sop_o(sop), .tx_eop_o(eop), .busy_o(bsy));

  int checks = 0, fails = 0, cyc = 0, frames = 0;
  logic [7:0] fr [72];
  bit m_busy = 0, m_pend = 0;
  int m_idx = 0;

  function automatic string tag(int i);
    if (i < 8) return "R3";
    if (i < 14) return "R4";
    if (i < 20) return "R5";
    if (i < 24) return "R6";
    if (i < 68) return "R7";
    return "R8";
  endfunction

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h cycle=%0d", r, act, exp, cyc);
    end
  endtask

  task automatic build(logic [47:0] a, logic [15:0] p);
    logic [31:0] c;
    for (int i = 0; i < 7; i++) fr[i] = 8'h55;
    fr[7] = 8'hD5;
    fr[8] = 8'h01; fr[9] = 8'h80; fr[10] = 8'hC2;
    fr[11] = 8'h00; fr[12] = 8'h00; fr[13] = 8'h01;
    for (int i = 0; i < 6; i++) fr[14+i] = a[47-8*i -: 8];
    fr[20] = 8'h88; fr[21] = 8'h08; fr[22] = 8'h00; fr[23] = 8'h01;
    fr[24] = p[15:8]; fr[25] = p[7:0];
    for (int i = 26; i < 68; i++) fr[i] = 8'h00;
    c = 32'hFFFFFFFF;
    for (int i = 8; i < 68; i++)
      for (int b = 0; b < 8; b++)
        c = ((c ^ 32'(fr[i][b])) & 1) != 0 ? (c >> 1) ^ 32'hEDB88320 : c >> 1;
    c = ~c;
    for (int i = 0; i < 4; i++) fr[68+i] = c[8*i +: 8];
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      bit done, rq;
      cyc++;
      done = m_busy && rdy && m_idx == 71;
      rq = req || m_pend;
      if (done) frames++;
      if (m_busy && rdy && !done) m_idx++;
      m_pend = m_busy && !done && rq;
      if (rq && (!m_busy || done)) begin
        build(sa, pt); m_idx = 0; m_busy = 1;
      end else if (done) m_busy = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", int'(v), int'(m_busy));
      chk("R11", int'(bsy), int'(m_busy));
      chk("R2", int'(sop), int'(m_busy && m_idx == 0));
      chk("R8", int'(eop), int'(m_busy && m_idx == 71));
      if (m_busy) chk(tag(m_idx), int'(d), int'(fr[m_idx]));
    end
  end

  task automatic pulse();
    req = 1; @(negedge clk); req = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (bsy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int base;
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1", int'({v, sop, eop, bsy}), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", int'({v, sop, eop, bsy}), 0);
        // single frame, ready always high
        pulse();
        chk("R2", int'({v, sop, bsy}), 7);
        wait_idle();
        chk("R11", frames, 1);
        // stalls with varying ready (R9), extreme pause time
        pt = 16'hFFFF; sa = 48'hFFEE_DDCC_BBAA;
        pulse();
        for (int k = 0; k < 400 && bsy; k++) begin
          rdy = (k % 3 != 1) && (k % 7 != 0);
          @(negedge clk);
        end
        rdy = 1;
        wait_idle();
        chk("R9", frames, 2);
        // two requests during one frame: one extra frame, inputs captured at start (R5, R7)
        pt = 16'h0000;
        base = frames;
        pulse();
        repeat (10) @(negedge clk);
        sa = 48'h1122_3344_5566; pt = 16'hA5C3;
        pulse();
        repeat (5) @(negedge clk);
        pulse();
        wait_idle();
        chk("R10", frames - base, 2);
        // request in the cycle the last byte is accepted
        base = frames;
        pulse();
        while (!eop) @(negedge clk);
        pulse();
        wait_idle();
        chk("R10", frames - base, 2);
        // reset mid-frame returns outputs to idle
        pulse();
        repeat (20) @(negedge clk);
        rst_n = 0; m_busy = 0; m_pend = 0;
        @(negedge clk);
        chk("R1", int'({v, sop, eop, bsy}), 0);
      end
      begin
        repeat (100000) @(negedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule